// File: doc/BRIEF.md
# Latched Process Trip Interlock with Gated Manual Reset

This block watches a set of trip channels that all command one shutdown actuator, for example the close command of an isolation valve. Each channel raises a trip condition either when its digital measurement reaches its programmable limit, or when its discrete trip contact is pulled low. A trip condition sets that channel's latch. A set latch keeps the actuator in its safe state after the condition goes away. Only an operator reset returns the plant to service. The operator gives that reset with a pushbutton, and the block accepts it only when a key switch is in its enable position.

All latches share one reset. That reset is accepted on a fresh press only while the key is enabled and no channel still has an active trip condition. The actuator is released only when every latch is clear. A reset-permitted indicator tells the operator panel whether a press would be accepted. A first-out record holds the index of the channel that tripped first since the last accepted reset.

A three-state controller handles reset acceptance. LOCKED means at least one latch is set and a reset is not permitted. ARMED means a reset is permitted and a press is awaited. RUN means every latch is clear and the actuator is released. The transitions are as follows:
- LOCKED to ARMED when a reset becomes permitted.
- ARMED to LOCKED when permission is lost.
- ARMED to RUN on an accepted press, which issues the clear.
- RUN to LOCKED as soon as any trip condition or latch appears.

Top module: `interlock_top`

## Requirements
- R1: A channel's trip condition is true when its unsigned measurement is greater than or equal to its threshold. A measurement one below the threshold does not trip. The latch shows the trip on the third rising edge after the input change: two synchronizer stages, then the latch.
- R2: A channel's discrete trip input is active low. A 0 on it trips that channel with the same three-edge latency as R1.
- R3: Each latch has set priority and never clears by itself. It stays set after its trip condition returns to normal, until an accepted reset.
- R4: A reset press is ignored while the enable key input is 0.
- R5: A reset press is ignored while the trip condition of any channel is still active.
- R6: A reset is taken only on a 0-to-1 edge of the synchronized pushbutton, and it clears every channel latch at once. The clear shows on the third rising edge after the press. Holding the button down does not clear a trip that appears later.
- R7: The actuator release output is 1 only when all channel latches are clear. Otherwise it is 0, which is the safe state.
- R8: After power-on reset, every channel latch is set, the actuator is safe, the first-out valid flag is 0 and reset-permitted is 0.
- R9: Reset-permitted is 1 exactly when the synchronized enable key is 1 and no trip condition is active. It follows its inputs on the second rising edge.
- R10: The first-out index records the lowest-numbered channel among those that set in the first trip cycle after a reset. Later trips leave it unchanged. An accepted reset clears its valid flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| meas_i | input | NCH*DW | Packed measurements, channel k at bits k*DW +: DW |
| thr_i | input | NCH*DW | Packed thresholds, same layout as meas_i |
| trip_n_i | input | NCH | Discrete trip contacts, active low |
| rst_btn_i | input | 1 | Manual reset pushbutton, 1 = pressed |
| rst_key_i | input | 1 | Reset enable key switch, 1 = enabled |
| act_run_o | output | 1 | Actuator release, 1 = normal operation, 0 = safe |
| tripped_o | output | NCH | Latched trip status per channel |
| reset_ok_o | output | 1 | Reset is currently permitted |
| first_idx_o | output | $clog2(NCH) | Index of the first channel to trip |
| first_vld_o | output | 1 | first_idx_o holds a valid record |

## Verification
A trip input or a comparison crossing reaches tripped_o and act_run_o on the third rising edge after the change. A change in the enable key or a trip condition reaches reset_ok_o on the second. A button press clears the latches on the third edge. The bench drives every input on a falling edge, counts falling edges from that point, and samples the outputs on the falling edge just after the edge where each result is due. For trips and resets it also checks one falling edge earlier, which confirms that the result has not arrived too soon. Checks that something is ignored are made after the full latency plus margin, at the status and actuator outputs.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_ARMED  = 2'd1,
        ST_RUN    = 2'd2
    } ilk_state_e;

endpackage

// File: rtl/ilk_sync.sv
module ilk_sync #(
    parameter int              W    = 1,
    parameter logic [W-1:0]    INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= INIT;
            stage2_q <= INIT;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;

endmodule

// File: rtl/ilk_channel.sv
module ilk_channel #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] meas_i,
    input  logic [DW-1:0] thr_i,
    input  logic          trip_n_i,
    input  logic          clear_i,
    output logic          cond_o,
    output logic          latched_o,
    output logic          new_set_o
);

    logic       over_raw;
    logic [1:0] sync_q;
    logic       latch_q;

    // Comparison on raw data, single-bit result synchronized.
    assign over_raw = (meas_i >= thr_i);

    ilk_sync #(
        .W    (2),
        .INIT (2'b01)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({over_raw, trip_n_i}),
        .q_o   (sync_q)
    );

    // sync_q[1]: over threshold, sync_q[0]: contact (active low)
    assign cond_o = sync_q[1] | ~sync_q[0];

    // Set-priority latch, tripped after power-on.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= 1'b1;
        end else if (cond_o) begin
            latch_q <= 1'b1;
        end else if (clear_i) begin
            latch_q <= 1'b0;
        end
    end

    assign latched_o = latch_q;
    assign new_set_o = cond_o & ~latch_q;

    p_set_prio_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        cond_o |=> latched_o);

    p_no_self_clear_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        (latched_o && !clear_i) |=> latched_o);

endmodule

// File: rtl/ilk_reset_fsm.sv
module ilk_reset_fsm
    import ilk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic btn_i,
    input  logic key_i,
    input  logic any_cond_i,
    input  logic any_latched_i,
    output logic clear_o,
    output logic permit_o
);

    logic [1:0]  ctl_sync;
    logic        btn_s;
    logic        key_s;
    logic        btn_prev_q;
    logic        btn_rise;
    ilk_state_e  state_q;
    ilk_state_e  state_d;

    ilk_sync #(
        .W    (2),
        .INIT (2'b00)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({btn_i, key_i}),
        .q_o   (ctl_sync)
    );

    assign btn_s = ctl_sync[1];
    assign key_s = ctl_sync[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            btn_prev_q <= 1'b0;
        end else begin
            btn_prev_q <= btn_s;
        end
    end

    assign btn_rise = btn_s & ~btn_prev_q;
    assign permit_o = key_s & ~any_cond_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: if (permit_o) state_d = ST_ARMED;
            ST_ARMED: begin
                if (!permit_o)     state_d = ST_LOCKED;
                else if (btn_rise) state_d = ST_RUN;
            end
            ST_RUN: if (any_cond_i || any_latched_i) state_d = ST_LOCKED;
            default: state_d = ST_LOCKED;
        endcase
    end

    // Outputs
    always_comb begin
        clear_o = 1'b0;
        unique case (state_q)
            ST_ARMED: clear_o = permit_o & btn_rise;
            ST_LOCKED, ST_RUN: clear_o = 1'b0;
            default: clear_o = 1'b0;
        endcase
    end

    p_clear_key_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        clear_o |-> key_s);

    p_clear_quiet_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        clear_o |-> !any_cond_i);

    p_clear_edge_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        clear_o |=> !clear_o);

endmodule

// File: rtl/ilk_first_out.sv
module ilk_first_out #(
    parameter int NCH = 4,
    parameter int IW  = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] new_set_i,
    input  logic           clear_i,
    output logic [IW-1:0]  idx_o,
    output logic           vld_o
);

    logic [IW-1:0] low_idx;
    logic [IW-1:0] idx_q;
    logic          vld_q;

    // Lowest-numbered newly set channel.
    always_comb begin
        low_idx = '0;
        for (int k = NCH - 1; k >= 0; k--) begin
            if (new_set_i[k]) low_idx = IW'(k);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            vld_q <= 1'b0;
        end else if (clear_i) begin
            vld_q <= 1'b0;
        end else if (!vld_q && (|new_set_i)) begin
            idx_q <= low_idx;
            vld_q <= 1'b1;
        end
    end

    assign idx_o = idx_q;
    assign vld_o = vld_q;

    p_fo_hold_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && !clear_i) |=> (vld_q && $stable(idx_q)));

endmodule

// File: rtl/interlock_top.sv
module interlock_top #(
    parameter int NCH = 4,
    parameter int DW  = 12,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH*DW-1:0] meas_i,
    input  logic [NCH*DW-1:0] thr_i,
    input  logic [NCH-1:0]    trip_n_i,
    input  logic              rst_btn_i,
    input  logic              rst_key_i,
    output logic              act_run_o,
    output logic [NCH-1:0]    tripped_o,
    output logic              reset_ok_o,
    output logic [IW-1:0]     first_idx_o,
    output logic              first_vld_o
);

    logic [NCH-1:0] cond;
    logic [NCH-1:0] latched;
    logic [NCH-1:0] new_set;
    logic           clr;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        ilk_channel #(
            .DW (DW)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .meas_i    (meas_i[g*DW +: DW]),
            .thr_i     (thr_i[g*DW +: DW]),
            .trip_n_i  (trip_n_i[g]),
            .clear_i   (clr),
            .cond_o    (cond[g]),
            .latched_o (latched[g]),
            .new_set_o (new_set[g])
        );
    end

    ilk_reset_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .btn_i         (rst_btn_i),
        .key_i         (rst_key_i),
        .any_cond_i    (|cond),
        .any_latched_i (|latched),
        .clear_o       (clr),
        .permit_o      (reset_ok_o)
    );

    ilk_first_out #(
        .NCH (NCH),
        .IW  (IW)
    ) u_fo (
        .clk       (clk),
        .rst_n     (rst_n),
        .new_set_i (new_set),
        .clear_i   (clr),
        .idx_o     (first_idx_o),
        .vld_o     (first_vld_o)
    );

    assign tripped_o = latched;
    assign act_run_o = ~(|latched);

    p_release_after_clear_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_run_o) |-> $past(clr));

    p_permit_quiet_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        reset_ok_o |-> (cond == '0));

endmodule

// File: tb/tb_interlock_top.sv
module tb_interlock_top;

    localparam int NCH = 4;
    localparam int DW  = 12;
    localparam int IW  = 2;
    localparam int THR = 300;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH*DW-1:0] meas = '0;
    logic [NCH*DW-1:0] thr = '0;
    logic [NCH-1:0]    trip_n = '1;
    logic              btn = 1'b0;
    logic              key = 1'b0;
    logic              act_run;
    logic [NCH-1:0]    tripped;
    logic              reset_ok;
    logic [IW-1:0]     first_idx;
    logic              first_vld;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    interlock_top #(.NCH(NCH), .DW(DW)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .meas_i      (meas),
        .thr_i       (thr),
        .trip_n_i    (trip_n),
        .rst_btn_i   (btn),
        .rst_key_i   (key),
        .act_run_o   (act_run),
        .tripped_o   (tripped),
        .reset_ok_o  (reset_ok),
        .first_idx_o (first_idx),
        .first_vld_o (first_vld)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_meas(input int ch, input int val);
        meas[ch*DW +: DW] = DW'(val);
    endtask

    task automatic press_release();
        btn = 1'b1;
        ticks(4);
        btn = 1'b0;
        ticks(4);
    endtask

    // R8: power-on state
    task automatic t_power_on();
        check("R8 tripped", int'(tripped), 15);
        check("R8 act_run", int'(act_run), 0);
        check("R8 first_vld", int'(first_vld), 0);
        check("R8 reset_ok", int'(reset_ok), 0);
    endtask

    // R9, R6, R7: first release with timing
    task automatic t_first_release();
        key = 1'b1;
        ticks(1);
        check("R9 reset_ok not yet", int'(reset_ok), 0);
        ticks(1);
        check("R9 reset_ok due", int'(reset_ok), 1);
        ticks(3);
        btn = 1'b1;
        ticks(2);
        check("R6 not cleared early", int'(tripped), 15);
        check("R7 still safe", int'(act_run), 0);
        ticks(1);
        check("R6 all cleared", int'(tripped), 0);
        check("R7 released", int'(act_run), 1);
        btn = 1'b0;
        ticks(4);
    endtask

    // R1: comparison boundary, R10 first-out
    task automatic t_threshold();
        set_meas(0, THR - 1);
        ticks(6);
        check("R1 below threshold", int'(tripped), 0);
        set_meas(0, THR);
        ticks(2);
        check("R1 not latched early", int'(tripped[0]), 0);
        ticks(1);
        check("R1 equal trips", int'(tripped), 1);
        check("R7 safe on trip", int'(act_run), 0);
        check("R10 first idx", int'(first_idx), 0);
        check("R10 first vld", int'(first_vld), 1);
        check("R9 reset_ok off", int'(reset_ok), 0);
    endtask

    // R3: latch holds after condition clears
    task automatic t_hold();
        set_meas(0, 100);
        ticks(8);
        check("R3 hold", int'(tripped), 1);
        check("R3 act safe", int'(act_run), 0);
        check("R9 reset_ok back", int'(reset_ok), 1);
    endtask

    // R4: key off blocks reset
    task automatic t_key_off();
        key = 1'b0;
        ticks(4);
        check("R9 reset_ok key off", int'(reset_ok), 0);
        press_release();
        check("R4 ignored", int'(tripped), 1);
        check("R4 act safe", int'(act_run), 0);
        key = 1'b1;
        ticks(4);
    endtask

    // R2, R5, R6 edge, R10 unchanged
    task automatic t_active_cond();
        trip_n[2] = 1'b0;
        ticks(2);
        check("R2 not latched early", int'(tripped[2]), 0);
        ticks(1);
        check("R2 contact trip", int'(tripped), 5);
        check("R10 idx unchanged", int'(first_idx), 0);
        btn = 1'b1;
        ticks(5);
        check("R5 ignored", int'(tripped), 5);
        trip_n[2] = 1'b1;
        ticks(6);
        check("R6 held button no clear", int'(tripped), 5);
        btn = 1'b0;
        ticks(4);
        press_release();
        check("R6 common clear", int'(tripped), 0);
        check("R7 release", int'(act_run), 1);
        check("R10 vld cleared", int'(first_vld), 0);
    endtask

    // R6: holding button cannot mask new trip
    task automatic t_held_button();
        btn = 1'b1;
        ticks(6);
        set_meas(3, 4000);
        ticks(3);
        check("R6 trip while held", int'(tripped), 8);
        set_meas(3, 0);
        ticks(8);
        check("R6 still latched", int'(tripped), 8);
        check("R10 idx ch3", int'(first_idx), 3);
        btn = 1'b0;
        ticks(4);
        press_release();
        check("R6 clear after new press", int'(tripped), 0);
    endtask

    // R10: simultaneous trips
    task automatic t_simultaneous();
        set_meas(1, THR + 5);
        trip_n[3] = 1'b0;
        ticks(3);
        check("R10 simultaneous", int'(tripped), 10);
        check("R10 lowest idx", int'(first_idx), 1);
        set_meas(0, THR);
        ticks(3);
        check("R10 later trip no change", int'(first_idx), 1);
        check("R1 ch0 trip", int'(tripped), 11);
        set_meas(0, 0);
        set_meas(1, 0);
        trip_n[3] = 1'b1;
        ticks(6);
        press_release();
        check("R6 final clear", int'(tripped), 0);
        check("R7 final release", int'(act_run), 1);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) begin
            thr[c*DW +: DW] = DW'(THR);
        end
        ticks(3);
        t_power_on();
        rst_n = 1'b1;
        ticks(1);
        t_power_on();
        t_first_release();
        t_threshold();
        t_hold();
        t_key_off();
        t_active_cond();
        t_held_button();
        t_simultaneous();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=complete");
            report();
        end
    end

endmodule